// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block predicts the next fetch address. Each cycle it can take one lookup: a fetch address and a hint giving the branch kind (conditional, jump, call or return). In the same cycle it returns a taken flag and a predicted next-fetch address. When the prediction is not taken, that address is the next sequential instruction, `lk_pc + 2**OFFSET_BITS`.

Jumps, calls and conditional branches are looked up in a direct-mapped target table. Each table entry holds a valid bit, a tag, a stored target and a two-bit direction state. Returns do not use the table. Their targets come from a small circular return stack: a call lookup pushes onto it and a return lookup pops from it.

The execute stage reports each resolved branch through a separate update port: the branch address, its kind, whether it was taken and its actual target. That report trains an existing entry or allocates a new one.

The direction state of each entry is a four-state machine:
- The states are `CT_STRONG_NT` (0), `CT_WEAK_NT` (1), `CT_WEAK_T` (2) and `CT_STRONG_T` (3).
- A taken resolution moves the state one step toward `CT_STRONG_T`, and a not-taken resolution moves it one step toward `CT_STRONG_NT`.
- A state already at either end stays there.

The return stack tracks its occupancy with a second state machine:
- The states are `RS_EMPTY`, `RS_PARTIAL` and `RS_FULL`.
- A push moves it from `RS_EMPTY` to `RS_PARTIAL`, and from `RS_PARTIAL` to `RS_FULL` once the last free slot is used.
- A pop moves it from `RS_FULL` back to `RS_PARTIAL`, and from `RS_PARTIAL` to `RS_EMPTY` when the last entry leaves.

Top module: `bp_fetch_predictor`

## Requirements
- R1: The table is direct-mapped with ENTRIES slots. The slot index is `pc[OFFSET_BITS +: log2(ENTRIES)]` and the tag is the remaining upper bits. A lookup hits only when the slot is valid and its tag matches, so two addresses that differ by `ENTRIES * 2**OFFSET_BITS` miss on each other's entry.
- R2: The `lk_kind` and `up_kind` encoding is 0 conditional, 1 jump, 2 call, 3 return. A conditional lookup that hits predicts taken when the entry's direction state is 2 or 3, with the stored target. An update for a conditional branch that hits moves the state one step toward 3 if taken, or toward 0 if not taken, and saturates at both ends.
- R3: A jump or call lookup that hits predicts taken with the stored target, whatever the entry's direction state.
- R4: A conditional lookup that misses predicts not taken, with target `lk_pc + 2**OFFSET_BITS`.
- R5: An update that misses allocates the slot if it is a jump, a call or a taken conditional. The new entry gets the update's tag and target and direction state 2. A not-taken conditional that misses allocates nothing, and return updates never change the table.
- R6: A taken update that hits replaces the stored target with `up_target`. A not-taken update that hits keeps the stored target.
- R7: A call lookup pushes `lk_pc + 2**OFFSET_BITS` onto the return stack. A return lookup on a non-empty stack pops the newest address and predicts taken to it. With `lk_valid` low, the stack is left untouched and the prediction is not taken.
- R8: The return stack holds RAS_DEPTH addresses. A push onto a full stack overwrites the oldest address. A return lookup on an empty stack predicts not taken, with the sequential target.
- R9: When an update writes the slot that the same cycle's lookup reads, the lookup sees the entry as written by that update.
- R10: Reset clears every valid bit and empties the return stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_pc | input | ADDR_W | Fetch address of the lookup |
| lk_kind | input | 2 | Branch kind hint of the lookup |
| pred_taken | output | 1 | Prediction is taken |
| pred_target | output | ADDR_W | Predicted next fetch address |
| up_valid | input | 1 | A resolved branch is reported this cycle |
| up_pc | input | ADDR_W | Address of the resolved branch |
| up_kind | input | 2 | Kind of the resolved branch |
| up_taken | input | 1 | Resolved direction |
| up_target | input | ADDR_W | Resolved target address |

## Verification
The bench builds the block with its defaults: ADDR_W 32, ENTRIES 128, OFFSET_BITS 2 and RAS_DEPTH 8. With these values, addresses 512 bytes apart share a slot, so tag aliasing can be reached with a few fetch addresses. An eight-deep stack is overflowed by ten calls and then drained past empty within a few dozen cycles. A randomized phase over a small address pool makes a same-slot update and lookup in one cycle frequent.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        BK_COND = 2'd0,
        BK_JUMP = 2'd1,
        BK_CALL = 2'd2,
        BK_RET  = 2'd3
    } br_kind_e;

    typedef enum logic [1:0] {
        CT_STRONG_NT = 2'd0,
        CT_WEAK_NT   = 2'd1,
        CT_WEAK_T    = 2'd2,
        CT_STRONG_T  = 2'd3
    } ctr_state_e;

    typedef enum logic [1:0] {
        RS_EMPTY,
        RS_PARTIAL,
        RS_FULL
    } ras_fill_e;

    // Direction state transition for one resolved conditional branch.
    function automatic ctr_state_e ctr_next(input ctr_state_e cur, input logic taken);
        ctr_state_e nxt;
        unique case (cur)
            CT_STRONG_NT: nxt = taken ? CT_WEAK_NT  : CT_STRONG_NT;
            CT_WEAK_NT:   nxt = taken ? CT_WEAK_T   : CT_STRONG_NT;
            CT_WEAK_T:    nxt = taken ? CT_STRONG_T : CT_WEAK_NT;
            CT_STRONG_T:  nxt = taken ? CT_STRONG_T : CT_WEAK_T;
            default:      nxt = CT_WEAK_T;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/bp_target_table.sv
module bp_target_table
    import bp_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int ENTRIES     = 128,
    parameter int OFFSET_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_hit,
    output ctr_state_e        lk_ctr,
    output logic [ADDR_W-1:0] lk_target,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  br_kind_e          up_kind,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W - OFFSET_BITS;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [ADDR_W-1:0]  tgt_q [ENTRIES];
    ctr_state_e         ctr_q [ENTRIES];

    logic [IDX_W-1:0] up_idx, lk_idx;
    logic [TAG_W-1:0] up_tag, lk_tag;
    logic             up_hit;

    logic              wr_en;
    logic [ADDR_W-1:0] wr_tgt;
    ctr_state_e        wr_ctr;

    assign up_idx = up_pc[OFFSET_BITS +: IDX_W];
    assign up_tag = up_pc[ADDR_W-1 -: TAG_W];
    assign lk_idx = lk_pc[OFFSET_BITS +: IDX_W];
    assign lk_tag = lk_pc[ADDR_W-1 -: TAG_W];
    assign up_hit = valid_q[up_idx] && (tag_q[up_idx] == up_tag);

    // Training and allocation decision for the resolved branch.
    always_comb begin
        wr_en  = 1'b0;
        wr_tgt = up_target;
        wr_ctr = CT_WEAK_T;
        if (up_valid && up_kind != BK_RET) begin
            if (up_hit) begin
                wr_en  = 1'b1;
                wr_tgt = up_taken ? up_target : tgt_q[up_idx];
                wr_ctr = (up_kind == BK_COND) ? ctr_next(ctr_q[up_idx], up_taken)
                                              : ctr_q[up_idx];
            end else if (up_taken || up_kind != BK_COND) begin
                wr_en  = 1'b1;
                wr_tgt = up_target;
                wr_ctr = CT_WEAK_T;
            end
        end
    end

    // Lookup read with forwarding of a same-slot write in this cycle.
    always_comb begin
        if (wr_en && up_idx == lk_idx) begin
            lk_hit    = (up_tag == lk_tag);
            lk_ctr    = wr_ctr;
            lk_target = wr_tgt;
        end else begin
            lk_hit    = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
            lk_ctr    = ctr_q[lk_idx];
            lk_target = tgt_q[lk_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[up_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[up_idx] <= up_tag;
            tgt_q[up_idx] <= wr_tgt;
            ctr_q[up_idx] <= wr_ctr;
        end
    end

    // R2: a taken resolution never pushes a strongly-taken entry off its end
    a_r2_saturate_high: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_hit && up_kind == BK_COND && up_taken && ctr_q[up_idx] == CT_STRONG_T)
        |=> ctr_q[$past(up_idx)] == CT_STRONG_T);

    // R5: a qualifying miss leaves its slot valid on the next cycle
    a_r5_alloc_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_hit && up_kind != BK_RET && (up_taken || up_kind != BK_COND))
        |=> valid_q[$past(up_idx)]);

endmodule

// File: rtl/bp_return_stack.sv
module bp_return_stack
    import bp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop,
    output logic [ADDR_W-1:0] top_addr,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]  wp_q, wp_inc, wp_dec;
    logic [CNT_W-1:0]  cnt_q;
    ras_fill_e         fill_q, fill_d;

    assign wp_inc   = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    assign wp_dec   = (wp_q == '0) ? LAST : wp_q - 1'b1;
    assign top_addr = slot_q[wp_dec];
    assign empty    = (fill_q == RS_EMPTY);

    // Occupancy state transitions.
    always_comb begin
        fill_d = fill_q;
        unique case (fill_q)
            RS_EMPTY:   if (push) fill_d = (DEPTH == 1) ? RS_FULL : RS_PARTIAL;
            RS_PARTIAL: begin
                if (push && cnt_q == FULL_CNT - 1'b1)      fill_d = RS_FULL;
                else if (pop && cnt_q == CNT_W'(1))        fill_d = RS_EMPTY;
            end
            RS_FULL:    if (pop) fill_d = (DEPTH == 1) ? RS_EMPTY : RS_PARTIAL;
            default:    fill_d = RS_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= RS_EMPTY;
            wp_q   <= '0;
            cnt_q  <= '0;
        end else begin
            fill_q <= fill_d;
            if (push) begin
                wp_q <= wp_inc;
                if (fill_q != RS_FULL) cnt_q <= cnt_q + 1'b1;
            end else if (pop && fill_q != RS_EMPTY) begin
                wp_q  <= wp_dec;
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push) slot_q[wp_q] <= push_addr;
    end

    // R8: occupancy never exceeds the stack depth
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);

    // R8: the empty state and the occupancy count agree
    a_r8_empty_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q == RS_EMPTY) == (cnt_q == '0));

    // R7: a push below full grows the occupancy by one
    a_r7_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fill_q != RS_FULL) |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/bp_fetch_predictor.sv
module bp_fetch_predictor
    import bp_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int ENTRIES     = 128,
    parameter int OFFSET_BITS = 2,
    parameter int RAS_DEPTH   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_pc,
    input  logic [1:0]        lk_kind,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_target,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic [1:0]        up_kind,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << OFFSET_BITS;

    br_kind_e          lk_k, up_k;
    logic              tb_hit;
    ctr_state_e        tb_ctr;
    logic [ADDR_W-1:0] tb_target, ras_top, seq_pc, chosen;
    logic              ras_empty, ras_push, ras_pop, taken;

    assign lk_k     = br_kind_e'(lk_kind);
    assign up_k     = br_kind_e'(up_kind);
    assign seq_pc   = lk_pc + STEP;
    assign ras_push = lk_valid && lk_k == BK_CALL;
    assign ras_pop  = lk_valid && lk_k == BK_RET;

    bp_target_table #(
        .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .OFFSET_BITS(OFFSET_BITS)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .lk_pc(lk_pc), .lk_hit(tb_hit), .lk_ctr(tb_ctr), .lk_target(tb_target),
        .up_valid(up_valid), .up_pc(up_pc), .up_kind(up_k),
        .up_taken(up_taken), .up_target(up_target)
    );

    bp_return_stack #(
        .ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)
    ) u_ras (
        .clk(clk), .rst_n(rst_n),
        .push(ras_push), .push_addr(seq_pc), .pop(ras_pop),
        .top_addr(ras_top), .empty(ras_empty)
    );

    always_comb begin
        taken  = 1'b0;
        chosen = tb_target;
        unique case (lk_k)
            BK_COND: taken = tb_hit && (tb_ctr == CT_WEAK_T || tb_ctr == CT_STRONG_T);
            BK_JUMP,
            BK_CALL: taken = tb_hit;
            BK_RET: begin
                taken  = !ras_empty;
                chosen = ras_top;
            end
            default: taken = 1'b0;
        endcase
        pred_taken  = lk_valid && taken;
        pred_target = (lk_valid && taken) ? chosen : seq_pc;
    end

    // R4: a conditional miss is never predicted taken
    a_r4_cond_miss_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_k == BK_COND && !tb_hit) |-> (!pred_taken && pred_target == seq_pc));

    // R3: jumps and calls that hit follow the stored target
    a_r3_jump_hit_redirects: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && (lk_k == BK_JUMP || lk_k == BK_CALL) && tb_hit)
        |-> (pred_taken && pred_target == tb_target));

    // R8: a return on an empty stack gives no redirect
    a_r8_empty_return: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_k == BK_RET && ras_empty) |-> !pred_taken);

endmodule

// File: tb/test_bp_fetch_predictor.sv
module test_bp_fetch_predictor;

    localparam int ADDR_W  = 32;
    localparam int ENTRIES = 128;
    localparam int DEPTH   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid = 1'b0;
    logic [ADDR_W-1:0] lk_pc = '0;
    logic [1:0]        lk_kind = '0;
    logic              pred_taken;
    logic [ADDR_W-1:0] pred_target;
    logic              up_valid = 1'b0;
    logic [ADDR_W-1:0] up_pc = '0;
    logic [1:0]        up_kind = '0;
    logic              up_taken = 1'b0;
    logic [ADDR_W-1:0] up_target = '0;

    always #10 clk = ~clk;

    bp_fetch_predictor #(
        .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .OFFSET_BITS(2), .RAS_DEPTH(DEPTH)
    ) i_bp_fetch_predictor (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_kind(lk_kind),
        .pred_taken(pred_taken), .pred_target(pred_target),
        .up_valid(up_valid), .up_pc(up_pc), .up_kind(up_kind),
        .up_taken(up_taken), .up_target(up_target)
    );

    // Behavioural reference: owner address per slot, integer direction, queue stack.
    bit          m_valid [ENTRIES];
    logic [31:0] m_owner [ENTRIES];
    logic [31:0] m_tgt   [ENTRIES];
    int          m_dir   [ENTRIES];
    logic [31:0] m_stack [$];

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    string req = "R10";

    function automatic int slot_of(logic [31:0] a);
        return int'((a >> 2) % ENTRIES);
    endfunction

    function automatic bit m_hit(logic [31:0] a);
        int s = slot_of(a);
        return m_valid[s] && (m_owner[s] >> 2) == (a >> 2);
    endfunction

    task automatic model_clear();
        for (int i = 0; i < ENTRIES; i++) m_valid[i] = 0;
        m_stack.delete();
    endtask

    task automatic model_update();
        int s;
        if (!up_valid || up_kind == 2'd3) return;
        s = slot_of(up_pc);
        if (m_hit(up_pc)) begin
            if (up_taken) m_tgt[s] = up_target;
            if (up_kind == 2'd0) begin
                if (up_taken && m_dir[s] < 3) m_dir[s]++;
                if (!up_taken && m_dir[s] > 0) m_dir[s]--;
            end
        end else if (up_taken || up_kind != 2'd0) begin
            m_valid[s] = 1;
            m_owner[s] = up_pc;
            m_tgt[s]   = up_target;
            m_dir[s]   = 2;
        end
    endtask

    task automatic check(string r, logic et, logic [31:0] etg);
        n_checks++;
        if (pred_taken !== et || pred_target !== etg) begin
            n_fail++;
            $display("FAIL %s pc=%h kind=%0d: got taken=%b target=%h, expected taken=%b target=%h",
                     r, lk_pc, lk_kind, pred_taken, pred_target, et, etg);
        end
    endtask

    // One cycle: drive at negedge, compare mid-phase, advance the model at the edge.
    task automatic step(bit lv, logic [31:0] lp, logic [1:0] lk,
                        bit uv, logic [31:0] upc, logic [1:0] uk, bit ut, logic [31:0] utg);
        logic        et;
        logic [31:0] etg, seq;
        int          s;
        lk_valid = lv; lk_pc = lp; lk_kind = lk;
        up_valid = uv; up_pc = upc; up_kind = uk; up_taken = ut; up_target = utg;
        model_update();
        seq = lp + 32'd4;
        s   = slot_of(lp);
        et  = 0;
        etg = m_tgt[s];
        case (lk)
            2'd0: et = m_hit(lp) && m_dir[s] >= 2;
            2'd1, 2'd2: et = m_hit(lp);
            default: begin
                et = m_stack.size() > 0;
                if (et) etg = m_stack[$];
            end
        endcase
        if (!lv) et = 0;
        if (!et) etg = seq;
        #3;
        check(req, et, etg);
        @(posedge clk);
        if (lv && lk == 2'd2) begin
            m_stack.push_back(seq);
            if (m_stack.size() > DEPTH) void'(m_stack.pop_front());
        end else if (lv && lk == 2'd3 && m_stack.size() > 0) begin
            void'(m_stack.pop_back());
        end
        @(negedge clk);
    endtask

    task automatic look(logic [31:0] p, logic [1:0] k);
        step(1, p, k, 0, 0, 0, 0, 0);
    endtask

    task automatic upd(logic [31:0] p, logic [1:0] k, bit t, logic [31:0] tg);
        step(0, 32'h40, 0, 1, p, k, t, tg);
    endtask

    task automatic do_reset();
        rst_n = 0;
        lk_valid = 0; up_valid = 0;
        repeat (2) @(negedge clk);
        model_clear();
        rst_n = 1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not complete, got hang, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();

        // R10: after reset nothing hits and the stack is empty
        req = "R10";
        look(32'h1000, 2'd1); look(32'h2000, 2'd0); look(32'h3000, 2'd3);

        // R5: allocation rules
        req = "R5";
        upd(32'h1000, 2'd1, 1, 32'h8000);
        look(32'h1000, 2'd1);
        upd(32'h1100, 2'd0, 0, 32'h9000);
        look(32'h1100, 2'd0); look(32'h1100, 2'd1);
        upd(32'h1200, 2'd3, 1, 32'hA000);
        look(32'h1200, 2'd1);

        // R1: alias 512 bytes away shares the slot but misses
        req = "R1";
        look(32'h1200 + 32'd512 - 32'h200, 2'd1);
        look(32'h1000 + 32'd512, 2'd1);

        // R2: counter walk and saturation at both ends
        req = "R2";
        upd(32'h2000, 2'd0, 1, 32'hB000);
        look(32'h2000, 2'd0);
        upd(32'h2000, 2'd0, 1, 32'hB000);
        upd(32'h2000, 2'd0, 1, 32'hB000);
        look(32'h2000, 2'd0);
        upd(32'h2000, 2'd0, 0, 32'h0);
        look(32'h2000, 2'd0);
        upd(32'h2000, 2'd0, 0, 32'h0);
        look(32'h2000, 2'd0);
        upd(32'h2000, 2'd0, 0, 32'h0);
        upd(32'h2000, 2'd0, 0, 32'h0);
        upd(32'h2000, 2'd0, 1, 32'hB000);
        look(32'h2000, 2'd0);

        // R3: jump or call lookup of a not-taken-state entry still redirects
        req = "R3";
        look(32'h2000, 2'd1); look(32'h2000, 2'd2);

        // R4: conditional miss goes sequential
        req = "R4";
        look(32'h5554, 2'd0);

        // R6: target replaced only by taken updates
        req = "R6";
        upd(32'h1000, 2'd1, 1, 32'h8800);
        look(32'h1000, 2'd1);
        upd(32'h1000, 2'd1, 0, 32'h1234);
        look(32'h1000, 2'd1);

        // R7: call then return pairs
        req = "R7";
        look(32'h3000, 2'd2); look(32'h3100, 2'd2);
        look(32'h3200, 2'd3); look(32'h3300, 2'd3);
        step(0, 32'h3400, 2'd2, 0, 0, 0, 0, 0);
        look(32'h3500, 2'd3);

        // R8: overflow wraps and over-popping ends not taken
        req = "R8";
        for (int i = 0; i < 10; i++) look(32'h4000 + 32'(i * 16), 2'd2);
        for (int i = 0; i < 10; i++) look(32'h4800, 2'd3);

        // R9: same-slot update and lookup in one cycle
        req = "R9";
        step(1, 32'h6000, 2'd1, 1, 32'h6000, 2'd1, 1, 32'hC000);
        step(1, 32'h6000, 2'd0, 1, 32'h6000 + 32'd512, 2'd0, 1, 32'hD000);
        step(1, 32'h6000 + 32'd512, 2'd0, 1, 32'h6000 + 32'd512, 2'd0, 0, 32'h0);

        // R10: mid-run reset forgets everything
        do_reset();
        req = "R10";
        look(32'h1000, 2'd1); look(32'h2000, 2'd0); look(32'h3000, 2'd3);

        // R1 mixed: randomized traffic over a small aliasing address pool
        req = "R1";
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a, b;
            a = 32'h7000 + 32'(($urandom % 6) * 4) + (($urandom % 2) ? 32'd512 : 32'd0);
            b = 32'h7000 + 32'(($urandom % 6) * 4) + (($urandom % 2) ? 32'd512 : 32'd0);
            step(($urandom % 8) != 0, a, 2'($urandom % 4),
                 ($urandom % 2) == 1, b, 2'($urandom % 4), ($urandom % 3) != 0,
                 32'hE000 + 32'(($urandom % 64) * 4));
        end

        finished = 1;
        summary();
        $finish;
    end

endmodule